// File: doc/BRIEF.md
# Subroutine Call and Return Sequencer

This block handles the control-flow part of subroutine calls and returns in a small 8-bit processor core. It keeps the program counter. When a call is accepted, it pushes the return address onto a byte-wide stack in data memory and then jumps to the target. When a return is accepted, it pops the saved address from the stack and jumps back. Four kinds of call are supported: an absolute target, a target relative to the return address, a target taken from a 16-bit pointer, and a target made of that pointer with an extension byte above it. Two kinds of return are supported: a plain return, and a return from an interrupt that also re-enables interrupts.

The stack pointer is 16 bits wide and belongs to the surrounding core. The unit samples it when a request is accepted and writes the final value back when the sequence ends. Memory traffic goes through one byte-wide port, one byte per clock. A configuration input selects how many address bytes each stack frame holds. In narrow mode a frame holds two bytes. In wide mode it holds three bytes, which covers a 22-bit program counter. Every new program-counter value is cut down to the implemented flash word-address width. Instruction fetch, decode and interrupt arbitration are handled elsewhere.

Top module: `call_return_unit`

## Requirements
- R1: A call writes the return address to memory one byte per clock, least significant byte first. The first byte goes to the sampled stack pointer (SP), the next to SP-1, and so on. `mem_we` is high only during these cycles.
- R2: In wide mode (`wide_pc`=1) a call pushes a third byte, holding return-address bits 21:16 with its top two bits zero. In narrow mode only two bytes are pushed.
- R3: A return reads memory one byte per clock at SP+1, SP+2, and SP+3 in wide mode. The first byte read is the most significant. The popped bytes, combined, become the new program counter.
- R4: When the sequence ends, `sp_we` pulses once. With it, `sp_wdata` carries SP minus the byte count for a call, or SP plus the byte count for a return, modulo 2^16. This includes wrapping through 0x0000/0xFFFF.
- R5: `req_op`=1 (relative call) jumps to `ret_pc` plus `rel_off`, where `rel_off` is sign-extended from 12 bits.
- R6: `req_op`=2 (pointer call) jumps to `z_ptr`. `req_op`=3 (extended pointer call) jumps to `{ext_hi, z_ptr}`.
- R7: `req_op`=0 (absolute call) jumps to `abs_target`. `req_op`=4 is a plain return and `req_op`=5 is a return from interrupt. Values 6 and 7 are ignored: no memory access, no busy cycle, and the program counter is unchanged.
- R8: `set_i` pulses together with `pc_valid` only at the end of a return from interrupt.
- R9: Every value loaded into `pc_out` is masked to the low FLASH_AW bits (17 by default).
- R10: After a request is accepted, `busy` stays high for exactly as many cycles as bytes are moved. In the next cycle `busy` is low and `pc_valid` pulses for one cycle with the new program counter. Requests that arrive while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wide_pc | input | 1 | 1: three-byte stack frames (22-bit PC); 0: two-byte frames |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_op | input | 3 | 0 abs call, 1 relative call, 2 pointer call, 3 extended pointer call, 4 return, 5 return from interrupt |
| ret_pc | input | 22 | Return address (word address of the next instruction) |
| abs_target | input | 22 | Absolute call target |
| rel_off | input | 12 | Signed relative offset |
| z_ptr | input | 16 | Pointer register value |
| ext_hi | input | 8 | Extension byte placed above the pointer |
| sp_in | input | 16 | Current stack pointer |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_wdata | output | 16 | New stack pointer value |
| mem_addr | output | 16 | Data memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe (read data is expected in the same cycle) |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| busy | output | 1 | Sequence in progress |
| pc_out | output | 22 | Program counter |
| pc_valid | output | 1 | One-cycle pulse when `pc_out` takes a new value |
| set_i | output | 1 | Pulse: set the global interrupt enable |

## Verification
Random requests mix all six operations with random stack pointers, return addresses, offsets, pointer values and mode. This shows whether each target source is chosen correctly, and whether two-byte and three-byte frames are told apart in both byte order and count. Directed cases cover the rest:
- pushing and popping across the 0x0000/0xFFFF stack-pointer wrap, which exposes a missing modulo;
- an all-ones absolute target and a negative relative offset that underflows, both of which expose missing masking or sign extension;
- a request issued during a sequence and the two unused operation codes, which tell a correctly ignored request from one that restarts or corrupts the sequence.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int PC_W = 22;
  localparam int XW   = 24;

  typedef enum logic [2:0] {
    OP_CALL   = 3'd0,
    OP_RCALL  = 3'd1,
    OP_ICALL  = 3'd2,
    OP_EICALL = 3'd3,
    OP_RET    = 3'd4,
    OP_RETI   = 3'd5,
    OP_RSV6   = 3'd6,
    OP_RSV7   = 3'd7
  } crt_op_e;

  // Keep only the implemented flash word-address bits.
  function automatic logic [PC_W-1:0] mask_pc(input logic [XW-1:0] v, input int aw);
    logic [XW-1:0] m;
    m = (XW'(1) << aw) - XW'(1);
    return PC_W'(v & m);
  endfunction

  // Base plus a 12-bit two's-complement offset, computed on the wide datapath.
  function automatic logic [XW-1:0] add_rel12(input logic [PC_W-1:0] base, input logic [11:0] off);
    return XW'(base) + {{(XW-12){off[11]}}, off};
  endfunction

  function automatic logic is_call(input crt_op_e op);
    return (op == OP_CALL) || (op == OP_RCALL) || (op == OP_ICALL) || (op == OP_EICALL);
  endfunction

  function automatic logic is_return(input crt_op_e op);
    return (op == OP_RET) || (op == OP_RETI);
  endfunction
endpackage

// File: rtl/crt_target.sv
module crt_target
  import crt_pkg::*;
#(
  parameter int FLASH_AW = 17
) (
  input  crt_op_e          op,
  input  logic [PC_W-1:0]  ret_pc,
  input  logic [PC_W-1:0]  abs_target,
  input  logic [11:0]      rel_off,
  input  logic [15:0]      z_ptr,
  input  logic [7:0]       ext_hi,
  output logic [PC_W-1:0]  target
);
  logic [XW-1:0] raw;

  always_comb begin
    case (op)
      OP_CALL:   raw = XW'(abs_target);
      OP_RCALL:  raw = add_rel12(ret_pc, rel_off);
      OP_ICALL:  raw = XW'(z_ptr);
      OP_EICALL: raw = {ext_hi, z_ptr};
      default:   raw = '0;
    endcase
    target = mask_pc(raw, FLASH_AW);
  end
endmodule

// File: rtl/crt_stack_engine.sv
module crt_stack_engine #(
  parameter  int SP_W   = 16,
  parameter  int NB_MAX = 3,
  localparam int DW     = 8 * NB_MAX,
  localparam int IW     = $clog2(NB_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            push,
  input  logic [IW-1:0]   nbytes,
  input  logic [DW-1:0]   wdata,
  input  logic [SP_W-1:0] sp_in,
  output logic            busy,
  output logic            xfer_last,
  output logic [DW-1:0]   rd_word,
  output logic [SP_W-1:0] mem_addr,
  output logic            mem_we,
  output logic            mem_re,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata,
  output logic            sp_we,
  output logic [SP_W-1:0] sp_wdata
);
  logic            active_q, push_q;
  logic [IW-1:0]   idx_q, nb_q;
  logic [SP_W-1:0] sp_q, sp_next;
  logic [DW-1:0]   data_q, acc_q;
  logic            last;

  always_comb begin
    sp_next   = push_q ? sp_q - SP_W'(1) : sp_q + SP_W'(1);
    last      = push_q ? (idx_q == nb_q - IW'(1)) : (idx_q == '0);
    mem_addr  = push_q ? sp_q : sp_q + SP_W'(1);
    mem_we    = active_q & push_q;
    mem_re    = active_q & ~push_q;
    mem_wdata = data_q[idx_q*8 +: 8];
    rd_word   = acc_q;
    rd_word[idx_q*8 +: 8] = mem_rdata;
    sp_we     = active_q & last;
    sp_wdata  = sp_next;
    busy      = active_q;
    xfer_last = active_q & last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      push_q   <= 1'b0;
      idx_q    <= '0;
      nb_q     <= '0;
      sp_q     <= '0;
      data_q   <= '0;
      acc_q    <= '0;
    end else if (!active_q) begin
      if (start) begin
        active_q <= 1'b1;
        push_q   <= push;
        nb_q     <= nbytes;
        sp_q     <= sp_in;
        data_q   <= wdata;
        acc_q    <= '0;
        idx_q    <= push ? '0 : nbytes - IW'(1);
      end
    end else begin
      sp_q <= sp_next;
      if (!push_q) acc_q <= rd_word;
      idx_q <= push_q ? idx_q + IW'(1) : idx_q - IW'(1);
      if (last) active_q <= 1'b0;
    end
  end

  // R1: successive pushes walk down the stack
  p_push_desc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - SP_W'(1)));
  // R3: successive pops walk up the stack
  p_pop_asc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + SP_W'(1)));
  // R10: single port, never read and write together
  p_port_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  // R4: stack pointer write-back only in a transfer cycle
  p_spwe_in_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> (mem_we || mem_re));
endmodule

// File: rtl/call_return_unit.sv
module call_return_unit
  import crt_pkg::*;
#(
  parameter int FLASH_AW = 17,
  parameter int SP_W     = 16,
  parameter logic [21:0] RESET_PC = 22'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wide_pc,
  input  logic        req_valid,
  input  logic [2:0]  req_op,
  input  logic [21:0] ret_pc,
  input  logic [21:0] abs_target,
  input  logic [11:0] rel_off,
  input  logic [15:0] z_ptr,
  input  logic [7:0]  ext_hi,
  input  logic [15:0] sp_in,
  output logic        sp_we,
  output logic [15:0] sp_wdata,
  output logic [15:0] mem_addr,
  output logic        mem_we,
  output logic        mem_re,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        busy,
  output logic [21:0] pc_out,
  output logic        pc_valid,
  output logic        set_i
);
  localparam int NB_WIDE   = (PC_W + 7) / 8;
  localparam int NB_NARROW = 2;
  localparam int IW        = $clog2(NB_WIDE + 1);
  localparam int DW        = 8 * NB_WIDE;

  crt_op_e         op_in, op_q;
  logic [PC_W-1:0] tgt_now, tgt_q, pc_q;
  logic            pc_valid_q, set_i_q;
  logic            accept, eng_busy, eng_last;
  logic [IW-1:0]   nbytes;
  logic [DW-1:0]   push_word, rd_word;

  assign op_in     = crt_op_e'(req_op);
  assign accept    = req_valid & ~eng_busy & (is_call(op_in) | is_return(op_in));
  assign nbytes    = wide_pc ? IW'(NB_WIDE) : IW'(NB_NARROW);
  assign push_word = wide_pc ? DW'(ret_pc) : DW'(ret_pc[15:0]);

  crt_target #(.FLASH_AW(FLASH_AW)) u_target (
    .op(op_in), .ret_pc(ret_pc), .abs_target(abs_target), .rel_off(rel_off),
    .z_ptr(z_ptr), .ext_hi(ext_hi), .target(tgt_now)
  );

  crt_stack_engine #(.SP_W(SP_W), .NB_MAX(NB_WIDE)) u_engine (
    .clk(clk), .rst_n(rst_n), .start(accept), .push(is_call(op_in)),
    .nbytes(nbytes), .wdata(push_word), .sp_in(sp_in), .busy(eng_busy),
    .xfer_last(eng_last), .rd_word(rd_word), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .sp_we(sp_we), .sp_wdata(sp_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q       <= OP_CALL;
      tgt_q      <= '0;
      pc_q       <= RESET_PC;
      pc_valid_q <= 1'b0;
      set_i_q    <= 1'b0;
    end else begin
      if (accept) begin
        op_q  <= op_in;
        tgt_q <= tgt_now;
      end
      pc_valid_q <= eng_last;
      set_i_q    <= eng_last & (op_q == OP_RETI);
      if (eng_last)
        pc_q <= is_call(op_q) ? tgt_q : mask_pc(rd_word, FLASH_AW);
    end
  end

  assign busy     = eng_busy;
  assign pc_out   = pc_q;
  assign pc_valid = pc_valid_q;
  assign set_i    = set_i_q;

  // R9: loaded program counter never exceeds the flash width
  p_pc_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_valid |-> ((XW'(pc_out) >> FLASH_AW) == '0));
  // R8: interrupt enable only at a completion
  p_seti_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |-> pc_valid);
  // R10: completion is reported with busy already low
  p_valid_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pc_valid |-> !busy);
  // R10: program counter moves only with a completion pulse
  p_pc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_valid |-> $stable(pc_out));
endmodule

// File: tb/call_return_unit_tb.sv
module call_return_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_pc = 1'b0, req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [21:0] ret_pc = '0, abs_target = '0;
  logic [11:0] rel_off = '0;
  logic [15:0] z_ptr = '0;
  logic [7:0]  ext_hi = '0;
  logic [15:0] sp_reg = '0;
  logic        sp_we, mem_we, mem_re, busy, pc_valid, set_i;
  logic [15:0] sp_wdata, mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [21:0] pc_out;
  logic        sp_load = 1'b0;
  logic [15:0] sp_load_val = '0;

  logic [7:0]  rmem [0:255];
  int          wlog_a [0:1023];
  int          wlog_d [0:1023];
  int          rlog_a [0:1023];
  int          wn = 0, rn = 0;
  int          tests = 0, fails = 0;
  localparam int MASK = (1 << 17) - 1;

  always #5 clk = ~clk;

  call_return_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wide_pc(wide_pc), .req_valid(req_valid),
    .req_op(req_op), .ret_pc(ret_pc), .abs_target(abs_target), .rel_off(rel_off),
    .z_ptr(z_ptr), .ext_hi(ext_hi), .sp_in(sp_reg), .sp_we(sp_we),
    .sp_wdata(sp_wdata), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .pc_out(pc_out),
    .pc_valid(pc_valid), .set_i(set_i)
  );

  assign mem_rdata = rmem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (sp_we) sp_reg <= sp_wdata;
    else if (sp_load) sp_reg <= sp_load_val;
    if (mem_we) begin
      wlog_a[wn % 1024] = int'(mem_addr);
      wlog_d[wn % 1024] = int'(mem_wdata);
      wn = wn + 1;
    end
    if (mem_re) begin
      rlog_a[rn % 1024] = int'(mem_addr);
      rn = rn + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int sext12(input int v);
    return (v & 12'h800) ? (v | ~32'hFFF) : (v & 32'hFFF);
  endfunction

  function automatic int exp_target(input int op, input int rp, input int ab,
                                    input int off, input int z, input int ex);
    case (op)
      0: return ab & MASK;
      1: return (rp + sext12(off)) & MASK;
      2: return z & MASK;
      3: return ((ex << 16) | z) & MASK;
      default: return 0;
    endcase
  endfunction

  task automatic run_op(input int op, input bit wide, input int rp, input int ab,
                        input int off, input int z, input int ex, input int sp,
                        input bit junk);
    int n, wn0, rn0, cnt, expc, expsp;
    string tag;
    n = wide ? 3 : 2;
    @(negedge clk);
    sp_load = 1'b1; sp_load_val = 16'(sp);
    @(negedge clk);
    sp_load = 1'b0;
    wn0 = wn; rn0 = rn;
    wide_pc = wide; req_op = 3'(op); ret_pc = 22'(rp); abs_target = 22'(ab);
    rel_off = 12'(off); z_ptr = 16'(z); ext_hi = 8'(ex); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 0;
    while (busy && cnt < 10) begin
      if (junk && cnt == 0) begin
        req_valid = 1'b1; req_op = (op < 4) ? 3'd4 : 3'd0; sp_load_val = 16'h1234;
      end else req_valid = 1'b0;
      cnt++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(cnt == n, "R10 busy cycles", cnt, n);
    chk(pc_valid == 1'b1, "R10 pc_valid pulse", int'(pc_valid), 1);
    chk(set_i == (op == 5), "R8 set_i", int'(set_i), int'(op == 5));
    if (op < 4) begin
      expc = exp_target(op, rp, ab, off, z, ex);
      expsp = (sp - n) & 16'hFFFF;
      case (op)
        0: tag = "R7 absolute target";
        1: tag = "R5 relative target";
        2: tag = "R6 pointer target";
        default: tag = "R6 extended pointer target";
      endcase
      chk(int'(pc_out) == expc, tag, int'(pc_out), expc);
      chk(wn - wn0 == n, "R2 push byte count", wn - wn0, n);
      for (int k = 0; k < n && k < wn - wn0; k++) begin
        int ea, ed;
        ea = (sp - k) & 16'hFFFF;
        ed = (k == 2) ? ((rp >> 16) & 8'h3F) : ((rp >> (8 * k)) & 8'hFF);
        chk(wlog_a[(wn0 + k) % 1024] == ea, "R1 push address", wlog_a[(wn0 + k) % 1024], ea);
        chk(wlog_d[(wn0 + k) % 1024] == ed, (k == 2) ? "R2 top byte" : "R1 push data",
            wlog_d[(wn0 + k) % 1024], ed);
      end
    end else begin
      expc = 0;
      expsp = (sp + n) & 16'hFFFF;
      for (int k = 0; k < n; k++) expc = (expc << 8) | int'(rmem[(sp + 1 + k) & 8'hFF]);
      expc = expc & MASK;
      chk(int'(pc_out) == expc, "R3 popped address", int'(pc_out), expc);
      chk(rn - rn0 == n, "R3 pop byte count", rn - rn0, n);
      for (int k = 0; k < n && k < rn - rn0; k++) begin
        int ea;
        ea = (sp + 1 + k) & 16'hFFFF;
        chk(rlog_a[(rn0 + k) % 1024] == ea, "R3 pop address", rlog_a[(rn0 + k) % 1024], ea);
      end
    end
    chk(int'(sp_reg) == expsp, "R4 stack pointer write-back", int'(sp_reg), expsp);
    chk((int'(pc_out) & ~MASK) == 0, "R9 pc mask", int'(pc_out), expc);
    @(negedge clk);
    chk(!busy && !pc_valid, "R10 no extra sequence", int'({busy, pc_valid}), 0);
  endtask

  task automatic run_reserved(input int op);
    int wn0, rn0, pcb, seen;
    wn0 = wn; rn0 = rn; pcb = int'(pc_out); seen = 0;
    @(negedge clk);
    req_op = 3'(op); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (busy || pc_valid) seen = 1;
      @(negedge clk);
    end
    chk(seen == 0, "R7 reserved op no busy", seen, 0);
    chk(wn == wn0 && rn == rn0, "R7 reserved op no memory access", (wn - wn0) + (rn - rn0), 0);
    chk(int'(pc_out) == pcb, "R7 reserved op pc unchanged", int'(pc_out), pcb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    for (int i = 0; i < 256; i++) rmem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    chk(pc_out == 22'h0 && !busy && !pc_valid && !set_i, "R10 reset state",
        int'({pc_out, busy, pc_valid, set_i}), 0);
    chk(!mem_we && !mem_re, "R1 reset no memory access", int'({mem_we, mem_re}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed corners
    run_op(0, 1'b1, 22'h2A_BC_DE, 22'h3F_FFFF, 0, 0, 0, 16'h0001, 1'b0); // R1 R2 R9 wrap
    run_op(4, 1'b1, 0, 0, 0, 0, 0, 16'hFFFE, 1'b0);                      // R3 R4 wrap
    run_op(1, 1'b0, 22'h00_0002, 0, 12'hFFC, 0, 0, 16'h0100, 1'b0);      // R5 negative
    run_op(1, 1'b1, 22'h01_0FF0, 0, 12'h7FF, 0, 0, 16'h0200, 1'b0);      // R5 positive
    run_op(3, 1'b1, 22'h12_3456, 0, 0, 16'hBEEF, 8'h3F, 16'h0300, 1'b0); // R6
    run_op(2, 1'b0, 22'h00_1234, 0, 0, 16'hCAFE, 8'h01, 16'h0000, 1'b0); // R6 R4
    run_op(5, 1'b0, 0, 0, 0, 0, 0, 16'h00F0, 1'b0);                      // R8
    run_op(5, 1'b1, 0, 0, 0, 0, 0, 16'hFFFF, 1'b0);                      // R8 R3
    run_op(0, 1'b0, 22'h00_4321, 22'h00_0777, 0, 0, 0, 16'h0400, 1'b1);  // R10 ignore
    run_op(4, 1'b0, 0, 0, 0, 0, 0, 16'h0050, 1'b1);                      // R10 ignore
    run_reserved(6);
    run_reserved(7);

    for (int i = 0; i < 60; i++) begin
      run_op(int'($urandom % 6), 1'($urandom), int'($urandom & 32'h3F_FFFF),
             int'($urandom & 32'h3F_FFFF), int'($urandom & 32'hFFF),
             int'($urandom & 32'hFFFF), int'($urandom & 32'hFF),
             int'($urandom & 32'hFFFF), 1'($urandom % 4 == 0));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule